// File: doc/BRIEF.md
# Vectored Interrupt Receive Latch

This block receives a vectored device interrupt that arrives as a level on a single line, together with a six-bit interrupt number. When the line is high and the latch is idle, the latch takes the arrival on the next clock edge. It sets its busy flag and builds the first of three 64-bit data words from a fixed all-ones field and the interrupt number. It clears the other two words, loads the vector trap type, raises a hard interrupt request and gives a one-cycle wake pulse to a halted core.

While busy, the latch ignores the line and the interrupt number, so the captured data stays unchanged. The latch frees itself when the line goes low. It acts on the sampled level in every cycle, not on an edge. An arrival that is still high after a release is therefore taken again at once. The reset input is asserted asynchronously and released in step with the clock.

Top module: `ivec_rx_latch`

## Requirements
- R1: While reset is asserted, and in the first cycles after its synchronised release, busy, request and wake are 0, all three data words are 0, and the trap type is 0.
- R2: A clock edge that samples the line high with busy low sets busy and the request to 1 after that edge.
- R3: On capture, word 0 becomes {53'b0, 5'b11111, num[5:0]}: bits 10 to 6 are all ones, bits 5 to 0 hold the sampled interrupt number, and all other bits are 0. Its value is 0x7C0 + num.
- R4: On capture, data words 1 and 2 become 0.
- R5: On capture, the 9-bit trap type becomes the vector-interrupt code 0x060.
- R6: The wake output is high for exactly the one cycle after a capturing edge and is low at all other times.
- R7: An edge that samples the line high while busy changes nothing. Busy, request, all words and the trap type keep their values, and wake stays low, even if the interrupt number has changed.
- R8: An edge that samples the line low while busy clears busy and the request. The data words and the trap type keep their values.
- R9: An edge that samples the line low while not busy changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 1 | Level-sensitive vectored interrupt line |
| irq_num | input | 6 | Interrupt number presented with the line |
| busy | output | 1 | Latch holds an unserviced vector |
| word0 | output | 64 | Data word 0: all-ones field above the number |
| word1 | output | 64 | Data word 1 (zero on capture) |
| word2 | output | 64 | Data word 2 (zero on capture) |
| hard_req | output | 1 | Hard interrupt request |
| trap_type | output | 9 | Trap type of the pending request |
| wake | output | 1 | One-cycle pulse that releases a halted core |

## Verification
A release and a new arrival can fall on neighbouring edges. The line is low for one edge, so the latch frees itself, and high again on the next edge with a different number, so the latch must capture again at once. The bench runs this for all 64 interrupt numbers. After each release it checks that busy and the request fell while the old word stayed. One edge later it checks that word 0 carries the new number and that wake pulses again. The bench also changes the number while busy is set, and judges that case by word 0 staying unchanged and wake staying low.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int unsigned NUM_W     = 6;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned N_WORDS   = 3;
  localparam int unsigned TT_W      = 9;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BUSY_BIT  = 5;
  localparam int unsigned TAG_LSB   = 6;
  localparam int unsigned TAG_W     = 5;
  localparam logic [TT_W-1:0] TT_VECTOR = 9'h060;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_CAPTURE = 2'd1,
    EV_RELEASE = 2'd2
  } ivec_event_e;
endpackage

// File: rtl/ivec_rst_sync.sv
module ivec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/ivec_status_ctl.sv
module ivec_status_ctl
  import ivec_pkg::*;
#(
  parameter int unsigned SW = STAT_W,
  parameter int unsigned BB = BUSY_BIT
) (
  input  logic        clk,
  input  logic        rst_q_n,
  input  logic        irq_line,
  output ivec_event_e evt,
  output logic        busy,
  output logic        hard_req,
  output logic        wake
);
  logic [SW-1:0] stat_q, stat_d;
  logic          req_q, req_d;
  logic          wake_q, wake_d;
  logic          stat_en;

  always_comb begin
    if (irq_line && !stat_q[BB])      evt = EV_CAPTURE;
    else if (!irq_line && stat_q[BB]) evt = EV_RELEASE;
    else                              evt = EV_NONE;
  end

  always_comb begin
    stat_en = (evt != EV_NONE);
    stat_d  = stat_q;
    req_d   = req_q;
    wake_d  = (evt == EV_CAPTURE);
    case (evt)
      EV_CAPTURE: begin
        stat_d[BB] = 1'b1;
        req_d      = 1'b1;
      end
      EV_RELEASE: begin
        stat_d[BB] = 1'b0;
        req_d      = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stat_q <= '0;
      req_q  <= 1'b0;
    end else if (stat_en) begin
      stat_q <= stat_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) wake_q <= 1'b0;
    else          wake_q <= wake_d;
  end

  assign busy     = stat_q[BB];
  assign hard_req = req_q;
  assign wake     = wake_q;
endmodule

// File: rtl/ivec_data_regs.sv
module ivec_data_regs
  import ivec_pkg::*;
#(
  parameter int unsigned NW = NUM_W,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned NWORDS = N_WORDS,
  parameter int unsigned TW = TT_W
) (
  input  logic                 clk,
  input  logic                 rst_q_n,
  input  ivec_event_e          evt,
  input  logic [NW-1:0]        irq_num,
  output logic [NWORDS*WW-1:0] words,
  output logic [TW-1:0]        trap_type
);
  localparam int unsigned HI_W = WW - TAG_LSB - TAG_W;

  logic          cap_en;
  logic [WW-1:0] head_word;
  logic [TW-1:0] tt_q;

  assign cap_en = (evt == EV_CAPTURE);

  always_comb begin
    head_word = {{HI_W{1'b0}}, {TAG_W{1'b1}}, {(TAG_LSB-NW){1'b0}}, irq_num};
  end

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      logic [WW-1:0] w_q, w_d;
      if (gi == 0) begin : g_head
        assign w_d = head_word;
      end else begin : g_tail
        assign w_d = '0;
      end
      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n)    w_q <= '0;
        else if (cap_en) w_q <= w_d;
      end
      assign words[gi*WW +: WW] = w_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    tt_q <= '0;
    else if (cap_en) tt_q <= TT_VECTOR;
  end

  assign trap_type = tt_q;
endmodule

// File: rtl/ivec_rx_latch.sv
module ivec_rx_latch
  import ivec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_line,
  input  logic [NUM_W-1:0]     irq_num,
  output logic                 busy,
  output logic [WORD_W-1:0]    word0,
  output logic [WORD_W-1:0]    word1,
  output logic [WORD_W-1:0]    word2,
  output logic                 hard_req,
  output logic [TT_W-1:0]      trap_type,
  output logic                 wake
);
  logic                        rst_q_n;
  ivec_event_e                 evt;
  logic [N_WORDS*WORD_W-1:0]   words;

  ivec_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ivec_status_ctl u_ctl (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .irq_line (irq_line),
    .evt      (evt),
    .busy     (busy),
    .hard_req (hard_req),
    .wake     (wake)
  );

  ivec_data_regs u_data (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .evt       (evt),
    .irq_num   (irq_num),
    .words     (words),
    .trap_type (trap_type)
  );

  assign word0 = words[0*WORD_W +: WORD_W];
  assign word1 = words[1*WORD_W +: WORD_W];
  assign word2 = words[2*WORD_W +: WORD_W];
endmodule

// File: rtl/ivec_rx_latch_chk.sv
module ivec_rx_latch_chk
  import ivec_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              irq_line,
  input logic [NUM_W-1:0]  irq_num,
  input logic              busy,
  input logic [WORD_W-1:0] word0,
  input logic [WORD_W-1:0] word1,
  input logic [WORD_W-1:0] word2,
  input logic              hard_req,
  input logic [TT_W-1:0]   trap_type,
  input logic              wake
);
  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_line && !busy) |=> (busy && hard_req));

  // R3
  head_word_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_line && !busy) |=> (word0 == (64'h7C0 | {58'b0, $past(irq_num)})));

  // R4
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_line && !busy) |=> (word1 == 64'b0 && word2 == 64'b0));

  // R5
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_line && !busy) |=> (trap_type == 9'h060));

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wake |=> !wake);

  // R6
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy) |-> wake);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && irq_line) |=> (busy && $stable(word0) && $stable(trap_type) && !wake));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && !irq_line) |=> (!busy && !hard_req && $stable(word0)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && !irq_line) |=> (!busy && !hard_req && !wake && $stable(word0)));
endmodule

bind ivec_rx_latch ivec_rx_latch_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .irq_line  (irq_line),
  .irq_num   (irq_num),
  .busy      (busy),
  .word0     (word0),
  .word1     (word1),
  .word2     (word2),
  .hard_req  (hard_req),
  .trap_type (trap_type),
  .wake      (wake)
);

// File: tb/ivec_rx_latch_bench.sv
module ivec_rx_latch_bench;
  logic        clk;
  logic        rst_n;
  logic        irq_line;
  logic [5:0]  irq_num;
  logic        busy;
  logic [63:0] word0, word1, word2;
  logic        hard_req;
  logic [8:0]  trap_type;
  logic        wake;

  int checks;
  int errors;
  bit done;

  ivec_rx_latch u_ivec_rx_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_line  (irq_line),
    .irq_num   (irq_num),
    .busy      (busy),
    .word0     (word0),
    .word1     (word1),
    .word2     (word2),
    .hard_req  (hard_req),
    .trap_type (trap_type),
    .wake      (wake)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(negedge clk);
  endtask

  function automatic logic [63:0] head(input logic [5:0] n);
    return 64'd1984 + {58'd0, n};
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    done = 0;
    rst_n = 1'b0;
    irq_line = 1'b0;
    irq_num = 6'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {63'd0, busy}, 64'd0);
    chk("R1", {63'd0, hard_req}, 64'd0);
    chk("R1", {63'd0, wake}, 64'd0);
    chk("R1", word0 | word1 | word2, 64'd0);
    chk("R1", {55'd0, trap_type}, 64'd0);
    // line high while reset asserted: no capture
    irq_line = 1'b1;
    @(negedge clk);
    chk("R1", {63'd0, busy}, 64'd0);
    irq_line = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {63'd0, busy}, 64'd0);
    chk("R9", word0, 64'd0);

    for (int n = 0; n < 64; n++) begin
      logic [63:0] prev_w0;
      prev_w0 = word0;
      // R9: idle edge with line low
      irq_num = 6'(n);
      edge_step();
      chk("R9", {62'd0, busy, wake}, 64'd0);
      chk("R9", word0, prev_w0);
      // capture
      irq_line = 1'b1;
      edge_step();
      chk("R2", {62'd0, busy, hard_req}, 64'd3);
      chk("R3", word0, head(6'(n)));
      chk("R4", word1 | word2, 64'd0);
      chk("R5", {55'd0, trap_type}, 64'h060);
      chk("R6", {63'd0, wake}, 64'd1);
      // held while busy with a different number
      irq_num = 6'(n) ^ 6'h2A;
      edge_step();
      chk("R6", {63'd0, wake}, 64'd0);
      chk("R7", word0, head(6'(n)));
      chk("R7", {62'd0, busy, hard_req}, 64'd3);
      edge_step();
      chk("R7", word0, head(6'(n)));
      // release
      irq_line = 1'b0;
      edge_step();
      chk("R8", {62'd0, busy, hard_req}, 64'd0);
      chk("R8", word0, head(6'(n)));
      chk("R8", {55'd0, trap_type}, 64'h060);
      // immediate re-arrival with a new number
      irq_line = 1'b1;
      irq_num = 6'(63 - n);
      edge_step();
      chk("R2", {62'd0, busy, hard_req}, 64'd3);
      chk("R3", word0, head(6'(63 - n)));
      chk("R6", {63'd0, wake}, 64'd1);
      irq_line = 1'b0;
      edge_step();
      chk("R8", {62'd0, busy, hard_req}, 64'd0);
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule